// File: doc/BRIEF.md
# I2C Byte-Command Master

This block is a single-master I2C controller that software steers one byte at a time. For each byte it supplies a data value, a pair of framing flags (open and close), an acknowledge choice for received bytes, and a one-cycle `go` strobe. The block then drives SCL and SDA as open-drain lines. Each line has an output enable (1 pulls the wire low) and a raw input sample. Depending on the flags, the block produces an opening condition, a byte with its acknowledge slot, and a closing condition.

The least significant bit of a byte sent under the open flag picks the direction of the bytes that follow it: 0 keeps the block transmitting and 1 switches it to receiving. The flag values are owned by software and the block never alters them. When the byte finishes, the block raises a one-cycle completion pulse. It also presents the last received byte, the acknowledge level the slave returned, the current direction, a sticky arbitration-lost flag, and a bus-busy flag taken from the lines.

Every SCL bit is split into four quarters of `QTR_CYC` clock cycles. SDA only changes in quarters where SCL is held low. The exceptions are the open and close conditions, which move SDA while SCL is high.

Top module: `i2c_byte_master`

## Requirements
- R1: `go` is accepted only while `busy` is 0. A `go` pulse during a transfer has no effect on the line waveform or on the completion timing.
- R2: With open=1, close=0 and the bus not owned, the line pairs (scl_oe, sda_oe) run through the quarters (0,0),(0,0),(0,1),(1,1). The byte follows MSB first, with sda_oe = inverse of the bit in all four quarters of each bit, and scl_oe = 1 in quarters 0 and 3 and 0 in quarters 1 and 2.
- R3: When the bus is already owned, open=1 gives a repeated opening whose first quarter is (1,0). The bus stays owned afterwards, with idle lines (1,0).
- R4: With open=0 and close=0, one byte plus its acknowledge slot is moved, with no opening or closing quarters.
- R5: With close=1 the open flag is ignored. The byte and its acknowledge slot are followed by closing quarters (1,1),(0,1),(0,0),(0,0). The bus is then released with idle lines (0,0) and the direction returns to transmit.
- R6: After an opening byte whose LSB is 1, `recv_mode` is 1. In the bytes that follow, sda_oe stays 0 in the data bits and `rx_byte` collects SDA MSB first. In the acknowledge slot sda_oe equals the inverse of `nak_sel`.
- R7: A close command in receive mode releases SDA in its acknowledge slot (a NAK) whatever the value of `nak_sel`, and then closes.
- R8: After each transmitted byte, `ack_rcvd` holds the SDA level seen in its acknowledge slot (0 = acknowledged, 1 = not acknowledged).
- R9: `busy` is 1 from the cycle after an accepted `go`. `done` is a single-cycle pulse in the first cycle in which `busy` is 0 again.
- R10: If a transmitted 1 (or the high SDA before an opening) reads low while SCL is high, `arb_lost` becomes 1, both enables go to 0, `done` pulses and ownership is dropped. `arb_lost` clears on the next accepted `go`.
- R11: `bus_busy` sets when SDA falls while SCL is high and clears when SDA rises while SCL is high.
- R12: An open request made while `bus_busy` is 1 and the bus is not owned leaves both enables at 0 and `busy` at 1 until `bus_busy` falls. The opening sequence then starts.
- R13: Each quarter lasts exactly `QTR_CYC` clock cycles, so one SCL bit takes 4*`QTR_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Launches one byte command |
| start_flag | input | 1 | Open flag: START or repeated START before the byte |
| stop_flag | input | 1 | Close flag: STOP after the byte |
| nak_sel | input | 1 | 1 = release SDA (NAK) after a received byte |
| tx_byte | input | 8 | Byte to send (address plus direction bit when opening) |
| scl_i | input | 1 | Sampled SCL wire |
| sda_i | input | 1 | Sampled SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Command in progress |
| rx_byte | output | 8 | Last received byte |
| ack_rcvd | output | 1 | Acknowledge level from the slave after the last transmitted byte |
| recv_mode | output | 1 | 1 = data bytes are received |
| arb_lost | output | 1 | Arbitration lost on the last command |
| bus_busy | output | 1 | Bus held between a seen START and STOP |

## Verification
A wrong phase or bit counter appears on `scl_oe`/`sda_oe` within one quarter, because the bench compares both enables against a per-quarter expectation on every clock. A stale direction bit or ownership flag shows at the next command. It appears as a driven data bit where a released one was expected, or as a first opening quarter of (0,0) in place of (1,0). Capture faults in the receive shifter or acknowledge sampling show at the `done` pulse of the byte concerned. Faults in the line monitor show as `bus_busy` disagreeing after an opening or closing, or as an open request that fails to wait.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_START = 3'd2,
        ST_BIT   = 3'd3,
        ST_STOP  = 3'd4
    } state_e;

    typedef struct packed {
        state_e     st;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic [7:0] rxsh;
        logic [7:0] rxb;
        logic       xmit;
        logic       addr;
        logic       rw;
        logic       stopc;
        logic       nak;
        logic       owned;
        logic       rmode;
        logic       ackr;
        logic       arbl;
        logic       done;
    } ctl_t;

endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_qtick.sv
module i2c_bm_qtick #(
    parameter int QTR_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LAST) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R13
endmodule

// File: rtl/i2c_bm_linemon.sv
module i2c_bm_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_busy
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } mon_t;

    mon_t m_d, m_q;

    always_comb begin
        m_d       = m_q;
        m_d.scl_p = scl_s;
        m_d.sda_p = sda_s;
        if (scl_s && m_q.scl_p && m_q.sda_p && !sda_s)      m_d.busy = 1'b1;
        else if (scl_s && m_q.scl_p && !m_q.sda_p && sda_s) m_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0};
        else        m_q <= m_d;
    end

    assign bus_busy = m_q.busy;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int QTR_CYC     = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       start_flag,
    input  logic       stop_flag,
    input  logic       nak_sel,
    input  logic [7:0] tx_byte,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done,
    output logic       busy,
    output logic [7:0] rx_byte,
    output logic       ack_rcvd,
    output logic       recv_mode,
    output logic       arb_lost,
    output logic       bus_busy
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    ctl_t r_d, r_q;
    logic scl_s, sda_s, tick, run, bit_oe, lose;

    i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
    i2c_bm_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
    i2c_bm_linemon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy));

    assign run = (r_q.st == ST_START) || (r_q.st == ST_BIT) || (r_q.st == ST_STOP);

    i2c_bm_qtick #(.QTR_CYC(QTR_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

    // Line drive from registered state only
    always_comb begin
        if (r_q.bitn < ACK_SLOT) bit_oe = r_q.xmit & ~r_q.sh[7];
        else                     bit_oe = ~r_q.xmit & ~r_q.nak;
        case (r_q.st)
            ST_START: begin
                scl_oe = (r_q.ph == 2'd0) ? r_q.owned : (r_q.ph == 2'd3);
                sda_oe = r_q.ph[1];
            end
            ST_BIT: begin
                scl_oe = (r_q.ph == 2'd0) || (r_q.ph == 2'd3);
                sda_oe = bit_oe;
            end
            ST_STOP: begin
                scl_oe = (r_q.ph == 2'd0);
                sda_oe = ~r_q.ph[1];
            end
            default: begin
                scl_oe = r_q.owned;
                sda_oe = 1'b0;
            end
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        lose     = 1'b0;
        case (r_q.st)
            ST_IDLE: if (go) begin
                r_d.arbl  = 1'b0;
                r_d.stopc = stop_flag;
                r_d.addr  = start_flag & ~stop_flag;
                r_d.xmit  = (start_flag & ~stop_flag) | ~r_q.rmode;
                r_d.sh    = tx_byte;
                r_d.rw    = tx_byte[0];
                r_d.nak   = stop_flag | nak_sel;
                r_d.ph    = 2'd0;
                r_d.bitn  = 4'd0;
                if (stop_flag || !start_flag)   r_d.st = ST_BIT;
                else if (!r_q.owned && bus_busy) r_d.st = ST_WAIT;
                else                             r_d.st = ST_START;
            end
            ST_WAIT: if (!bus_busy) begin
                r_d.st = ST_START;
                r_d.ph = 2'd0;
            end
            ST_START: if (tick) begin
                if (r_q.ph == 2'd1 && !sda_s) lose = 1'b1;
                else if (r_q.ph == 2'd3) begin
                    r_d.owned = 1'b1;
                    r_d.st    = ST_BIT;
                    r_d.ph    = 2'd0;
                end else r_d.ph = r_q.ph + 2'd1;
            end
            ST_BIT: if (tick) begin
                if (r_q.ph == 2'd1) begin
                    r_d.ph = 2'd2;
                    if (r_q.bitn < ACK_SLOT) begin
                        if (r_q.xmit) lose = r_q.sh[7] & ~sda_s;
                        else          r_d.rxsh = {r_q.rxsh[6:0], sda_s};
                    end else if (r_q.xmit) begin
                        r_d.ackr = sda_s;
                    end
                end else if (r_q.ph == 2'd3) begin
                    r_d.ph = 2'd0;
                    if (r_q.bitn < ACK_SLOT) begin
                        r_d.sh   = {r_q.sh[6:0], 1'b0};
                        r_d.bitn = r_q.bitn + 4'd1;
                    end else begin
                        if (r_q.addr)  r_d.rmode = r_q.rw;
                        if (!r_q.xmit) r_d.rxb   = r_q.rxsh;
                        if (r_q.stopc) r_d.st = ST_STOP;
                        else begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                    end
                end else r_d.ph = r_q.ph + 2'd1;
            end
            ST_STOP: if (tick) begin
                if (r_q.ph == 2'd3) begin
                    r_d.st    = ST_IDLE;
                    r_d.owned = 1'b0;
                    r_d.rmode = 1'b0;
                    r_d.done  = 1'b1;
                end else r_d.ph = r_q.ph + 2'd1;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (lose) begin
            r_d.st    = ST_IDLE;
            r_d.owned = 1'b0;
            r_d.rmode = 1'b0;
            r_d.arbl  = 1'b1;
            r_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done      = r_q.done;
    assign busy      = (r_q.st != ST_IDLE);
    assign rx_byte   = r_q.rxb;
    assign ack_rcvd  = r_q.ackr;
    assign recv_mode = r_q.rmode;
    assign arb_lost  = r_q.arbl;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!scl_oe && !sda_oe)); // R10
    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STOP && $fell(sda_oe)) |-> !scl_oe); // R5
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BIT && r_q.ph == 2'd2) |-> $stable(sda_oe)); // R4
    AST_WAIT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> (!scl_oe && !sda_oe)); // R12
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    localparam int QTR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       go = 1'b0, start_flag = 1'b0, stop_flag = 1'b0, nak_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       slave_pull = 1'b0;
    logic       scl_i, sda_i, scl_oe, sda_oe, done, busy, ack_rcvd, recv_mode, arb_lost, bus_busy;
    logic [7:0] rx_byte;

    assign scl_i = ~scl_oe;
    assign sda_i = ~(sda_oe | slave_pull);

    i2c_byte_master #(.QTR_CYC(QTR)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_flag(start_flag), .stop_flag(stop_flag),
        .nak_sel(nak_sel), .tx_byte(tx_byte), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .busy(busy), .rx_byte(rx_byte),
        .ack_rcvd(ack_rcvd), .recv_mode(recv_mode), .arb_lost(arb_lost), .bus_busy(bus_busy));

    int n_chk = 0;
    int n_err = 0;
    bit owned_m = 1'b0;
    bit rmode_m = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: builds the expected per-quarter line pairs and slave
    // response, then compares every clock of the command.
    task automatic run_cmd(input bit st, input bit sp, input bit nk, input logic [7:0] b,
                           input logic [7:0] rxd, input bit ack_pull, input int lose_bit,
                           input int inject_q, input string req);
        bit qs[$];
        bit qd[$];
        bit ql[$];
        bit addr, xm, lost, nak_eff;
        addr    = st && !sp;
        xm      = addr || !rmode_m;
        lost    = 1'b0;
        nak_eff = sp || nk;
        if (addr) begin
            qs.push_back(owned_m); qd.push_back(1'b0); ql.push_back(1'b0);
            qs.push_back(1'b0);    qd.push_back(1'b0); ql.push_back(1'b0);
            qs.push_back(1'b0);    qd.push_back(1'b1); ql.push_back(1'b0);
            qs.push_back(1'b1);    qd.push_back(1'b1); ql.push_back(1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            if (!lost) begin
                bit dv, sv;
                dv = xm ? !b[7-i] : 1'b0;
                sv = xm ? (i == lose_bit) : !rxd[7-i];
                qs.push_back(1'b1); qd.push_back(dv); ql.push_back(sv);
                qs.push_back(1'b0); qd.push_back(dv); ql.push_back(sv);
                if (xm && i == lose_bit) lost = 1'b1;
                else begin
                    qs.push_back(1'b0); qd.push_back(dv); ql.push_back(sv);
                    qs.push_back(1'b1); qd.push_back(dv); ql.push_back(sv);
                end
            end
        end
        if (!lost) begin
            bit dv, sv;
            dv = xm ? 1'b0 : !nak_eff;
            sv = xm ? ack_pull : 1'b0;
            qs.push_back(1'b1); qd.push_back(dv); ql.push_back(sv);
            qs.push_back(1'b0); qd.push_back(dv); ql.push_back(sv);
            qs.push_back(1'b0); qd.push_back(dv); ql.push_back(sv);
            qs.push_back(1'b1); qd.push_back(dv); ql.push_back(sv);
            if (sp) begin
                qs.push_back(1'b1); qd.push_back(1'b1); ql.push_back(1'b0);
                qs.push_back(1'b0); qd.push_back(1'b1); ql.push_back(1'b0);
                qs.push_back(1'b0); qd.push_back(1'b0); ql.push_back(1'b0);
                qs.push_back(1'b0); qd.push_back(1'b0); ql.push_back(1'b0);
            end
        end
        @(negedge clk);
        start_flag = st; stop_flag = sp; nak_sel = nk; tx_byte = b; go = 1'b1;
        foreach (qs[i]) begin
            for (int k = 0; k < QTR; k++) begin
                logic [3:0] e;
                @(negedge clk);
                go = (i == inject_q) && (k == 0);   // R1: mid-transfer go must be ignored
                if (k == 0) slave_pull = ql[i];
                e = {1'b1, 1'b0, qs[i], qd[i]};
                chk({busy, done, scl_oe, sda_oe} == e, req,
                    $sformatf("busy/done/scl/sda quarter %0d cycle %0d (R13)", i, k),
                    {busy, done, scl_oe, sda_oe}, e);
            end
        end
        if (addr && !lost) begin owned_m = 1'b1; rmode_m = b[0]; end
        if (sp || lost) begin owned_m = 1'b0; rmode_m = 1'b0; end
        @(negedge clk);
        go = 1'b0;
        if (!lost) slave_pull = 1'b0;
        chk({busy, done, scl_oe, sda_oe} == {1'b0, 1'b1, owned_m, 1'b0}, "R9",
            "end-of-command busy/done/scl/sda", {busy, done, scl_oe, sda_oe},
            {1'b0, 1'b1, owned_m, 1'b0});
        chk(recv_mode == rmode_m, "R6", "recv_mode after command", recv_mode, rmode_m);
        @(negedge clk);
        chk(!done, "R9", "done single cycle", done, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({scl_oe, sda_oe, busy, done, bus_busy, arb_lost, recv_mode} == 7'd0, "R9",
            "reset outputs", {scl_oe, sda_oe, busy, done, bus_busy, arb_lost, recv_mode}, 0);

        // R2 R1 R8 R11: fresh opening, write address, slave acknowledges
        run_cmd(1, 0, 0, 8'hA4, 8'h00, 1, -1, 5, "R2");
        chk(ack_rcvd == 1'b0, "R8", "ack after address", ack_rcvd, 0);
        chk(bus_busy == 1'b1, "R11", "bus_busy after opening", bus_busy, 1);

        // R4 R8: plain data byte, slave does not acknowledge
        run_cmd(0, 0, 0, 8'h5B, 8'h00, 0, -1, -1, "R4");
        chk(ack_rcvd == 1'b1, "R8", "nak after data", ack_rcvd, 1);

        // R3 R6: repeated opening with read direction
        run_cmd(1, 0, 0, 8'h4B, 8'h00, 1, -1, -1, "R3");
        chk(recv_mode == 1'b1, "R6", "receive mode after read address", recv_mode, 1);

        // R6: receive byte with ACK driven
        run_cmd(0, 0, 0, 8'h00, 8'h3C, 0, -1, -1, "R6");
        chk(rx_byte == 8'h3C, "R6", "rx_byte", rx_byte, 8'h3C);

        // R6: receive byte with NAK selected, no close
        run_cmd(0, 0, 1, 8'h00, 8'hC5, 0, -1, -1, "R6");
        chk(rx_byte == 8'hC5, "R6", "rx_byte nak", rx_byte, 8'hC5);

        // R7 R5: close in receive mode, open flag set but ignored, nak_sel=0
        run_cmd(1, 1, 0, 8'hFF, 8'h96, 0, -1, -1, "R7");
        chk(rx_byte == 8'h96, "R7", "rx_byte before close", rx_byte, 8'h96);
        chk(bus_busy == 1'b0, "R11", "bus_busy after close", bus_busy, 0);

        // R5: write address then transmit close byte with open flag ignored
        run_cmd(1, 0, 0, 8'h20, 8'h00, 1, -1, -1, "R2");
        run_cmd(1, 1, 0, 8'h81, 8'h00, 1, -1, -1, "R5");
        chk(recv_mode == 1'b0 && bus_busy == 1'b0, "R5", "released after close",
            {recv_mode, bus_busy}, 0);

        // R10: another master holds SDA low during the first address bit
        run_cmd(1, 0, 0, 8'hD0, 8'h00, 0, 0, -1, "R10");
        chk(arb_lost == 1'b1, "R10", "arb_lost set", arb_lost, 1);
        chk(bus_busy == 1'b1, "R11", "bus still busy after loss", bus_busy, 1);

        // R12: open request waits while the bus is busy and not owned
        @(negedge clk);
        start_flag = 1'b1; stop_flag = 1'b0; nak_sel = 1'b0; tx_byte = 8'h22; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(busy && !scl_oe && !sda_oe, "R12", "waiting with lines released",
                {busy, scl_oe, sda_oe}, 3'b100);
        end
        slave_pull = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 1000 && !seen; i++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(seen, "R12", "transfer after bus free", seen, 1);
        end
        chk(arb_lost == 1'b0, "R10", "arb_lost cleared by go", arb_lost, 0);
        chk(ack_rcvd == 1'b1, "R8", "no slave ack", ack_rcvd, 1);
        chk(bus_busy == 1'b1 && scl_oe == 1'b1, "R11", "owned after retry",
            {bus_busy, scl_oe}, 2'b11);
        owned_m = 1'b1;
        rmode_m = 1'b0;
        run_cmd(0, 1, 0, 8'h00, 8'h00, 1, -1, -1, "R5");
        chk(bus_busy == 1'b0, "R11", "bus free at end", bus_busy, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule